// File: doc/BRIEF.md
# Receive Bit-Clock Recovery Loop

This block recovers the bit clock of a serial receive stream that is sampled with a clock running `OSR` times faster than the bit rate. The incoming line passes through a synchronizer and an edge detector. When the loop is enabled it starts in search mode and waits for a transition. The first transition starts a phase counter that divides the oversampling clock into bit cells. In each cell the loop raises a sample strobe once, in the middle of the cell, and presents the synchronized line level next to it.

While the loop is tracking, transitions that fall close to a cell boundary pull the counter by one count. Transitions that fall elsewhere leave the counter alone. The loop supports two line codings. With NRZI coding, every boundary is examined, and a cell without a transition is treated as legal. With FM (biphase) coding, only every other boundary is examined. If a transition fails to appear at an examined boundary, a sticky flag is set. A second consecutive failure sets another flag and drops the loop back into search mode.

A receiver drives `en_i` and the coding select, and takes each bit from `rxd_o` when `smp_o` is high. The status reset `stat_clr_i` clears the two flags.

Top module: `rx_dpll`

## Requirements
- R1: While `rst_ni` is low, and on the clock edge after `en_i` is sampled low, `locked_o`, `miss1_o` and `miss2_o` go low. While `en_i` is low, transitions on `rxd_i` cause no lock and no strobe.
- R2: Once enabled, the loop stays in search mode until a transition arrives. In search mode `locked_o` and `smp_o` stay low. Lock is taken again after the loop falls back to search mode.
- R3: Let rising clock edge k be the first edge at which a changed `rxd_i` level is present. In search mode, `locked_o` is high after edge k+2, and the first `smp_o` is high in the cycle after edge k+9.
- R4: While tracking with no correction, `smp_o` is high for exactly one cycle in every `OSR` cycles, at counter value `OSR/2`. In that cycle `rxd_o` equals the level `rxd_i` had two clock edges earlier.
- R5: An accepted transition seen when the counter is in the last `WIN` counts of a cell shortens that cell by one count, so the next strobe comes one cycle earlier.
- R6: An accepted transition seen when the counter is at 1 to `WIN` lengthens the cell by one count, so the next strobe comes one cycle later. A transition at count 0 makes no change.
- R7: A transition seen more than `WIN` counts from a boundary changes nothing in the strobe schedule.
- R8: With `fm_mode_i`=1 (FM), only the boundaries into the lock cell and into every second cell after it are examined. Transitions near the other boundaries cause no correction.
- R9: With FM, the window of an examined boundary closes when the counter leaves count `WIN`. If no accepted transition came in that window, `miss1_o` is set after that edge.
- R10: With FM, two consecutive examined windows without a transition set `miss2_o` and drop `locked_o` on the same edge. Two misses separated by a hit do not set `miss2_o`.
- R11: With `fm_mode_i`=0 (NRZI), a line without transitions keeps the strobe running and never sets `miss1_o` or `miss2_o`.
- R12: `miss1_o` and `miss2_o` hold until `stat_clr_i` is sampled high or `en_i` is sampled low. If a new miss and the clear arrive on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, `OSR` times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Loop enable; low clears state and flags |
| fm_mode_i | input | 1 | Line coding: 1 for FM, 0 for NRZI |
| stat_clr_i | input | 1 | Clears the missing-transition flags |
| rxd_i | input | 1 | Asynchronous serial receive line |
| smp_o | output | 1 | One-cycle strobe at mid-cell |
| rxd_o | output | 1 | Synchronized line level, valid with `smp_o` |
| locked_o | output | 1 | Loop is tracking, not searching |
| miss1_o | output | 1 | Sticky: an examined window had no transition |
| miss2_o | output | 1 | Sticky: two consecutive examined windows were empty |

## Verification
The bench builds the block with its defaults: `OSR`=16, `WIN`=3 and two synchronizer stages. With these values every event falls on an exact cycle number counted from the driven transition. That covers both one-count corrections at offsets -1 and +1, an ignored mid-cell transition at offset +6, and the miss check, which resolves 6 cycles after an examined boundary. FM streams shift an unexamined boundary early and late, drop examined boundaries both back to back and apart, and then apply the clear and the disable. An NRZI stream runs long stretches without transitions.

// File: rtl/rx_dpll_pkg.sv
package rx_dpll_pkg;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_TRACK  = 1'b1
  } dpll_st_e;

  typedef enum logic [1:0] {
    CORR_NONE  = 2'd0,
    CORR_SHORT = 2'd1,
    CORR_LONG  = 2'd2
  } corr_e;

endpackage

// File: rtl/rx_dpll_sync.sv
module rx_dpll_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic edg_o
);

  logic [STAGES-1:0] sh_q;
  logic              prv_q;

  // STAGES must be at least 2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      prv_q <= 1'b0;
    end else begin
      sh_q  <= {sh_q[STAGES-2:0], d_i};
      prv_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o = sh_q[STAGES-1];
  assign edg_o = sh_q[STAGES-1] ^ prv_q;

endmodule

// File: rtl/rx_dpll_phase.sv
module rx_dpll_phase
  import rx_dpll_pkg::*;
#(
  parameter int OSR = 16,
  parameter int WIN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic start_i,
  input  logic fm_i,
  input  logic edg_i,
  output logic strobe_o,
  output logic hit_o,
  output logic eval_o
);

  // OSR must be a power of two, WIN below OSR/2 - 1
  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] HALF_C = PW'(OSR / 2);
  localparam logic [PW-1:0] WIN_C  = PW'(WIN);
  localparam logic [PW-1:0] ERLY_C = PW'(OSR - WIN);

  logic [PW-1:0] ph_q, ph_nxt, ph_adv;
  logic          par_q, par_nxt;
  logic          in_zero, in_late, in_early, win_open, wrap;
  corr_e         corr;

  always_comb begin
    in_zero  = (ph_q == '0);
    in_late  = (ph_q != '0) && (ph_q <= WIN_C);
    in_early = (ph_q >= ERLY_C);
    // FM: par_q=0 cells own the boundary they start with
    if (fm_i) win_open = par_q ? in_early : (in_zero || in_late);
    else      win_open = in_early || in_zero || in_late;
    hit_o = run_i && edg_i && win_open;

    corr = CORR_NONE;
    if (hit_o && in_early)     corr = CORR_SHORT;
    else if (hit_o && in_late) corr = CORR_LONG;

    case (corr)
      CORR_SHORT: ph_adv = ph_q + PW'(2);
      CORR_LONG:  ph_adv = ph_q;
      default:    ph_adv = ph_q + PW'(1);
    endcase
    wrap = (ph_adv < ph_q);

    if (start_i) begin
      ph_nxt  = PW'(1);
      par_nxt = 1'b0;
    end else if (!run_i) begin
      ph_nxt  = '0;
      par_nxt = 1'b0;
    end else begin
      ph_nxt  = ph_adv;
      par_nxt = par_q ^ wrap;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      par_q <= 1'b0;
    end else begin
      ph_q  <= ph_nxt;
      par_q <= par_nxt;
    end
  end

  assign strobe_o = run_i && (ph_q == HALF_C);
  // window of an examined boundary closes when the count leaves WIN
  assign eval_o   = run_i && fm_i && !par_q && (ph_q == WIN_C) && (corr != CORR_LONG);

endmodule

// File: rtl/rx_dpll_miss.sv
module rx_dpll_miss (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic start_i,
  input  logic hit_i,
  input  logic eval_i,
  output logic miss1_o,
  output logic miss2_o,
  output logic lost_o
);

  logic seen_q, run_q, m1_q, m2_q, miss;

  assign miss   = eval_i && !seen_q;
  assign lost_o = miss && run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      run_q  <= 1'b0;
      m1_q   <= 1'b0;
      m2_q   <= 1'b0;
    end else if (!en_i) begin
      seen_q <= 1'b0;
      run_q  <= 1'b0;
      m1_q   <= 1'b0;
      m2_q   <= 1'b0;
    end else begin
      if (start_i || hit_i) seen_q <= 1'b1;
      else if (eval_i)      seen_q <= 1'b0;

      if (start_i)     run_q <= 1'b0;
      else if (eval_i) run_q <= miss;

      if (miss)       m1_q <= 1'b1;
      else if (clr_i) m1_q <= 1'b0;

      if (lost_o)     m2_q <= 1'b1;
      else if (clr_i) m2_q <= 1'b0;
    end
  end

  assign miss1_o = m1_q;
  assign miss2_o = m2_q;

endmodule

// File: rtl/rx_dpll.sv
module rx_dpll
  import rx_dpll_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int WIN         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fm_mode_i,
  input  logic stat_clr_i,
  input  logic rxd_i,
  output logic smp_o,
  output logic rxd_o,
  output logic locked_o,
  output logic miss1_o,
  output logic miss2_o
);

  dpll_st_e st_q, st_d;
  logic     lvl, edg, trk, start, hit, eval, lost;

  assign trk   = (st_q == ST_TRACK);
  assign start = en_i && !trk && edg;

  always_comb begin
    st_d = st_q;
    if (!en_i)      st_d = ST_SEARCH;
    else if (start) st_d = ST_TRACK;
    else if (lost)  st_d = ST_SEARCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_SEARCH;
    else         st_q <= st_d;
  end

  rx_dpll_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .lvl_o  (lvl),
    .edg_o  (edg)
  );

  rx_dpll_phase #(
    .OSR (OSR),
    .WIN (WIN)
  ) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (trk),
    .start_i  (start),
    .fm_i     (fm_mode_i),
    .edg_i    (edg),
    .strobe_o (smp_o),
    .hit_o    (hit),
    .eval_o   (eval)
  );

  rx_dpll_miss u_miss (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .clr_i   (stat_clr_i),
    .start_i (start),
    .hit_i   (hit),
    .eval_i  (eval),
    .miss1_o (miss1_o),
    .miss2_o (miss2_o),
    .lost_o  (lost)
  );

  assign rxd_o    = lvl;
  assign locked_o = trk;

endmodule

// File: rtl/rx_dpll_chk.sv
module rx_dpll_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic fm_mode_i,
  input logic stat_clr_i,
  input logic rxd_i,
  input logic smp_o,
  input logic rxd_o,
  input logic locked_o,
  input logic miss1_o,
  input logic miss2_o
);

  // R1
  dis_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!locked_o && !miss1_o && !miss2_o));

  // R2
  lock_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(en_i));

  // R4
  smp_tracking_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_o |-> locked_o);

  // R4
  smp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_o |=> !smp_o);

  // R10
  miss2_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(miss2_o) |-> !locked_o);

  // R10
  miss2_has_miss1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss2_o |-> miss1_o);

  // R11
  nrzi_no_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(miss1_o) |-> $past(fm_mode_i));

  // R12
  miss1_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !stat_clr_i && miss1_o) |=> miss1_o);

  // R12
  miss2_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !stat_clr_i && miss2_o) |=> miss2_o);

endmodule

bind rx_dpll rx_dpll_chk u_chk (.*);

// File: tb/tb_rx_dpll.sv
module tb_rx_dpll;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic fm = 1'b0;
  logic clr = 1'b0;
  logic rxd = 1'b0;
  logic smp, rxd_q, locked, miss1, miss2;

  int cyc = 0;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  typedef struct {
    int    t;
    logic  d;
    string req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_dpll dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .fm_mode_i  (fm),
    .stat_clr_i (clr),
    .rxd_i      (rxd),
    .smp_o      (smp),
    .rxd_o      (rxd_q),
    .locked_o   (locked),
    .miss1_o    (miss1),
    .miss2_o    (miss2)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input int t, input logic d, input string req);
    exp_t e;
    e.t = t; e.d = d; e.req = req;
    q.push_back(e);
  endtask

  task automatic at_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic restart(input logic fm_sel);
    en = 1'b0;
    fm = fm_sel;
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && cyc > q[0].t) begin
        exp_t e;
        e = q.pop_front();
        chk(1'b0, e.req, "missing strobe at cycle", cyc, e.t);
      end
      if (smp) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", "unexpected strobe at cycle", cyc, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.t, e.req, "strobe cycle", cyc, e.t);
          chk(rxd_q == e.d, e.req, "sampled data", int'(rxd_q), int'(e.d));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int   t0, t1;
    logic l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!locked && !smp && !miss1 && !miss2, "R1", "outputs after reset",
        int'({locked, smp, miss1, miss2}), 0);

    // R1 disabled: transitions ignored
    for (int i = 0; i < 4; i++) begin
      at_cyc(cyc + 9);
      rxd = ~rxd;
    end
    at_cyc(cyc + 20);
    chk(!locked, "R1", "locked while disabled", int'(locked), 0);

    // R2 search with a quiet line
    restart(1'b0);
    at_cyc(cyc + 40);
    chk(!locked, "R2", "locked without transition", int'(locked), 0);

    // NRZI stream: lock, corrections, ignored edge, quiet stretch
    t0 = cyc + 2;
    l = rxd;
    push_exp(t0 + 10,  ~l, "R3");
    push_exp(t0 + 26,  ~l, "R4");
    push_exp(t0 + 42,   l, "R4");
    push_exp(t0 + 57,  ~l, "R5");
    push_exp(t0 + 73,   l, "R5");
    push_exp(t0 + 90,  ~l, "R6");
    push_exp(t0 + 106,  l, "R7");
    push_exp(t0 + 122, ~l, "R7");
    for (int j = 8; j < 12; j++) push_exp(t0 + 16 * j + 10, ~l, "R11");

    at_cyc(t0);
    rxd = ~rxd;
    at_cyc(t0 + 2);
    chk(!locked, "R3", "locked two cycles after change", int'(locked), 0);
    at_cyc(t0 + 3);
    chk(locked, "R3", "locked three cycles after change", int'(locked), 1);
    at_cyc(t0 + 32);  rxd = ~rxd;
    at_cyc(t0 + 47);  rxd = ~rxd;   // one early
    at_cyc(t0 + 63);  rxd = ~rxd;
    at_cyc(t0 + 80);  rxd = ~rxd;   // one late
    at_cyc(t0 + 102); rxd = ~rxd;   // mid cell, outside window
    at_cyc(t0 + 112); rxd = ~rxd;
    at_cyc(t0 + 190);
    chk(locked && !miss1 && !miss2, "R11", "NRZI quiet line status",
        int'({locked, miss1, miss2}), 4);
    chk(q.size() == 0, "R4", "strobes left pending", q.size(), 0);

    // FM stream: unexamined boundaries moved, then line goes quiet
    restart(1'b1);
    t0 = cyc + 2;
    l = rxd;
    for (int j = 0; j < 6; j++) begin
      l = ~l;
      push_exp(t0 + 16 * j + 10, l, (j == 1 || j == 3) ? "R8" : "R4");
    end
    push_exp(t0 + 106, l, "R9");
    push_exp(t0 + 122, l, "R9");
    for (int j = 0; j < 6; j++) begin
      at_cyc(t0 + 16 * j + ((j == 1) ? -1 : (j == 3) ? 1 : 0));
      rxd = ~rxd;
    end
    at_cyc(t0 + 101);
    chk(!miss1, "R9", "miss1 before window closes", int'(miss1), 0);
    at_cyc(t0 + 102);
    chk(miss1, "R9", "miss1 after empty window", int'(miss1), 1);
    chk(!miss2 && locked, "R9", "single miss keeps lock", int'({miss2, locked}), 1);
    at_cyc(t0 + 133);
    chk(locked && !miss2, "R10", "before second window closes", int'({locked, miss2}), 2);
    at_cyc(t0 + 134);
    chk(!locked && miss2, "R10", "after second empty window", int'({locked, miss2}), 1);

    // R12 sticky, then status clear
    at_cyc(t0 + 181);
    chk(miss1 && miss2 && !locked, "R12", "flags held in search",
        int'({miss1, miss2, locked}), 6);
    clr = 1'b1;
    at_cyc(t0 + 182);
    clr = 1'b0;
    at_cyc(t0 + 184);
    chk(!miss1 && !miss2, "R12", "flags after clear", int'({miss1, miss2}), 0);

    // R2 relock, R10 two misses apart
    t1 = t0 + 200;
    l = rxd;
    for (int j = 0; j < 8; j++) begin
      if (j != 2 && j != 6) l = ~l;
      push_exp(t1 + 16 * j + 10, l, (j == 0) ? "R2" : "R10");
    end
    for (int j = 0; j < 8; j++) begin
      if (j != 2 && j != 6) begin
        at_cyc(t1 + 16 * j);
        rxd = ~rxd;
      end
    end
    at_cyc(t1 + 104);
    chk(locked && miss1 && !miss2, "R10", "misses apart",
        int'({locked, miss1, miss2}), 6);

    // R12 disable clears flags, re-enable keeps them clear
    at_cyc(t1 + 126);
    en = 1'b0;
    at_cyc(t1 + 128);
    chk(!miss1 && !locked, "R12", "after disable", int'({miss1, locked}), 0);
    en = 1'b1;
    at_cyc(t1 + 132);
    chk(!miss1 && !miss2 && !locked, "R1", "after re-enable",
        int'({miss1, miss2, locked}), 0);
    chk(q.size() == 0, "R4", "strobes left pending", q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule